// File: doc/BRIEF.md
# Operate Group 2 Skip Evaluator

This block carries out the second group of microcoded operate instructions for a 12-bit accumulator machine. When an instruction is issued, the block tests the accumulator and the link against the conditions the instruction word selects, and decides whether the following instruction should be skipped. In the same instruction it can clear the accumulator, OR a 12-bit front-panel switch value into it, and request a halt.

A single sense bit changes how the three condition bits combine. When it is clear, the skip is taken if any selected condition is true. When it is set, the skip is taken only if every selected condition is false. With the sense bit set and no condition selected, the skip is always taken. The skip request and the new accumulator are registered results. The halt request is a strobe that appears one cycle after the accumulator update. The surrounding datapath owns the program counter and must act on `skip_req` itself. Words from other opcodes and from the other operate groups do nothing in this block.

Top module: `opr2_skip_unit`

## Requirements
- R1: An issue (`op_go` high) executes only if bits [11:9] of the word are 3'b111, bit [8] is 1 and bit [0] is 0. Any other word, and any cycle with `op_go` low, leaves `ac_out` unchanged and gives no skip and no halt.
- R2: When the sense bit [3] is 0, the skip is taken if any selected condition holds. Bit [6] selects "AC bit 11 is 1", bit [5] selects "AC equals zero" and bit [4] selects "link is 1". With none of them selected, there is no skip.
- R3: When the sense bit [3] is 1, the skip is taken only if no selected condition from R2 holds, which means every selected inverse holds (AC non-negative, AC nonzero, link zero).
- R4: When the sense bit [3] is 1 and bits [6:4] are all 0, the skip is always taken.
- R5: The skip decision uses the `ac_in` value from before any clear done by the same word.
- R6: Bit [7] clears the accumulator. Bit [2] ORs `switch_in` into the accumulator, and this happens after the clear, so setting both bits loads `switch_in`.
- R7: A group 2 word whose bits [7:1] are all 0 is a no-op: `ac_out` becomes `ac_in`, with no skip and no halt.
- R8: `ac_out` and `skip_req` take their new values in the cycle after the issue. `skip_req` is high for that one cycle only, unless the next cycle issues another word that skips.
- R9: Bit [1] raises `halt_pulse` for one cycle, two cycles after the issue, which is one cycle after the accumulator update.
- R10: While `rst_n` is low at a clock edge, `ac_out`, `skip_req` and `halt_pulse` are set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_go | input | 1 | Issue strobe for the word on `instr` |
| instr | input | 12 | Instruction word, bit 11 is the most significant |
| ac_in | input | 12 | Accumulator value before the instruction |
| link_in | input | 1 | Link bit |
| switch_in | input | 12 | Front-panel switch register |
| skip_req | output | 1 | Skip the next instruction (one-cycle pulse) |
| ac_out | output | 12 | Accumulator after the instruction (held) |
| halt_pulse | output | 1 | One-cycle halt request |

## Verification
The accumulator and the skip request are registered once, so for an issue sampled at edge N both can be seen just after edge N+1. The halt passes through one more stage and is due after edge N+2. The bench's reference model pushes each issue's expected results into stages of the same depth, one stage for the accumulator and skip and two for the halt. It compares all three outputs at every falling edge, which keeps clear of the edge where they change. Back-to-back issues and idle gaps are both driven, so these fixed latencies are also checked when results overlap.

// File: rtl/opr2_pkg.sv
// Package: shared types for the group 2 operate skip evaluator.
// Assumes: three selectable conditions, in a fixed order used by the decoder
// and by the condition evaluator.
package opr2_pkg;

    // Index of each selectable condition inside the condition vector
    typedef enum int {
        COND_NEG  = 0,
        COND_ZERO = 1,
        COND_LINK = 2
    } opr2_cond_e;

    localparam int NCOND = 3;

    // Decoded fields of one instruction word
    typedef struct packed {
        logic             is_g2;
        logic             clr_ac;
        logic [NCOND-1:0] cond_sel;
        logic             sense;
        logic             or_sw;
        logic             halt;
    } opr2_fields_t;

endpackage

// File: rtl/opr2_decode.sv
// Module: opr2_decode
// Splits an instruction word into group 2 operate fields.
// Assumes: bit WORD_W-1 is the most significant. The opcode sits in the top
// three bits. The group bit is just below them and the group discriminator is
// bit 0. All other field positions are fixed offsets from the top.
module opr2_decode
    import opr2_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] word,
    output opr2_fields_t      fields
);
    localparam int OPC_W    = 3;
    localparam int IDX_GRP  = WORD_W - 4;
    localparam int IDX_CLR  = WORD_W - 5;
    localparam int IDX_NEG  = WORD_W - 6;
    localparam int IDX_ZERO = WORD_W - 7;
    localparam int IDX_LINK = WORD_W - 8;
    localparam int IDX_SNS  = WORD_W - 9;
    localparam int IDX_OSR  = WORD_W - 10;
    localparam int IDX_HLT  = WORD_W - 11;
    localparam int IDX_G3   = 0;

    logic opc_is_opr;

    // Purpose: recognise the operate opcode (all ones in the top field)
    always_comb begin
        opc_is_opr = &word[WORD_W-1 -: OPC_W];
    end

    // Purpose: assemble the field struct from the word
    always_comb begin
        fields                     = '0;
        fields.is_g2               = opc_is_opr & word[IDX_GRP] & ~word[IDX_G3];
        fields.clr_ac              = word[IDX_CLR];
        fields.cond_sel[COND_NEG]  = word[IDX_NEG];
        fields.cond_sel[COND_ZERO] = word[IDX_ZERO];
        fields.cond_sel[COND_LINK] = word[IDX_LINK];
        fields.sense               = word[IDX_SNS];
        fields.or_sw               = word[IDX_OSR];
        fields.halt                = word[IDX_HLT];
    end
endmodule

// File: rtl/opr2_cond_eval.sv
// Module: opr2_cond_eval
// Works out the skip decision from the selected conditions and the sense bit.
// Assumes: ac and link are the values from before the instruction. With
// sense clear the result is the OR of the selected conditions. With sense set
// it is the AND of their inverses, which is true when nothing is selected.
module opr2_cond_eval
    import opr2_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] ac,
    input  logic              link,
    input  logic [NCOND-1:0]  cond_sel,
    input  logic              sense,
    output logic              skip
);
    logic [NCOND-1:0] cond_true;
    logic [NCOND-1:0] sel_hit;
    logic [NCOND-1:0] sel_ok;
    logic             any_hit;
    logic             all_ok;

    // Purpose: evaluate each raw condition on the pre-instruction state
    always_comb begin
        cond_true            = '0;
        cond_true[COND_NEG]  = ac[WORD_W-1];
        cond_true[COND_ZERO] = (ac == '0);
        cond_true[COND_LINK] = link;
    end

    // One lane per condition: hit for the OR form, pass for the AND form
    for (genvar gi = 0; gi < NCOND; gi++) begin : g_lane
        assign sel_hit[gi] = cond_sel[gi] & cond_true[gi];
        assign sel_ok[gi]  = ~cond_sel[gi] | ~cond_true[gi];
    end

    // Purpose: reduce the lanes and pick the form with the sense bit
    always_comb begin
        any_hit = |sel_hit;
        all_ok  = &sel_ok;
        skip    = sense ? all_ok : any_hit;
    end
endmodule

// File: rtl/opr2_acc_path.sv
// Module: opr2_acc_path
// Computes the new accumulator for a group 2 word.
// Assumes: the clear is done first and the switch OR second, so setting both
// loads the switch value.
module opr2_acc_path #(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] sw,
    input  logic              clr_ac,
    input  logic              or_sw,
    output logic [WORD_W-1:0] ac_new
);
    logic [WORD_W-1:0] after_clr;

    // Purpose: first step, optional clear
    always_comb begin
        after_clr = clr_ac ? '0 : ac;
    end

    // Purpose: second step, optional OR of the switch register
    always_comb begin
        ac_new = or_sw ? (after_clr | sw) : after_clr;
    end
endmodule

// File: rtl/opr2_skip_unit.sv
// Module: opr2_skip_unit (top)
// Executes group 2 operate words: skip decision, accumulator clear and switch
// OR, and halt request.
// Assumes: an issue is a single-cycle op_go with the operands valid in the
// same cycle. ac_out and skip_req are registered one cycle after the issue.
// halt_pulse follows one cycle after that. Reset is synchronous, active low.
module opr2_skip_unit
    import opr2_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_go,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] ac_in,
    input  logic              link_in,
    input  logic [WORD_W-1:0] switch_in,
    output logic              skip_req,
    output logic [WORD_W-1:0] ac_out,
    output logic              halt_pulse
);
    localparam int HALT_STAGES = 2;

    opr2_fields_t      fld;
    logic              skip_cmb;
    logic [WORD_W-1:0] ac_cmb;
    logic              exec;
    logic [WORD_W-1:0] ac_q;
    logic              skip_q;
    logic [HALT_STAGES-1:0] halt_sr;

    opr2_decode #(.WORD_W(WORD_W)) u_dec (
        .word   (instr),
        .fields (fld)
    );

    opr2_cond_eval #(.WORD_W(WORD_W)) u_cond (
        .ac       (ac_in),
        .link     (link_in),
        .cond_sel (fld.cond_sel),
        .sense    (fld.sense),
        .skip     (skip_cmb)
    );

    opr2_acc_path #(.WORD_W(WORD_W)) u_acc (
        .ac     (ac_in),
        .sw     (switch_in),
        .clr_ac (fld.clr_ac),
        .or_sw  (fld.or_sw),
        .ac_new (ac_cmb)
    );

    // Purpose: an issue counts only for a group 2 operate word
    always_comb begin
        exec = op_go & fld.is_g2;
    end

    // Purpose: register the accumulator result, held until the next issue
    always_ff @(posedge clk) begin
        if (!rst_n)    ac_q <= '0;
        else if (exec) ac_q <= ac_cmb;
    end

    // Purpose: register the skip decision as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) skip_q <= 1'b0;
        else        skip_q <= exec & skip_cmb;
    end

    // Purpose: delay the halt request so it trails the accumulator update
    always_ff @(posedge clk) begin
        if (!rst_n) halt_sr <= '0;
        else        halt_sr <= {halt_sr[HALT_STAGES-2:0], exec & fld.halt};
    end

    assign ac_out     = ac_q;
    assign skip_req   = skip_q;
    assign halt_pulse = halt_sr[HALT_STAGES-1];
endmodule

// File: rtl/opr2_skip_unit_chk.sv
// Module: opr2_skip_unit_chk
// Property checker for opr2_skip_unit, attached with bind below.
// Assumes: the same field positions as the decoder, decoded again here.
module opr2_skip_unit_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_go,
    input logic [WORD_W-1:0] instr,
    input logic [WORD_W-1:0] ac_in,
    input logic              link_in,
    input logic [WORD_W-1:0] switch_in,
    input logic              skip_req,
    input logic [WORD_W-1:0] ac_out,
    input logic              halt_pulse
);
    logic is_g2w;
    logic issue;
    logic s_sense, s_neg, s_zero, s_link, s_clr, s_osr, s_hlt;

    // Purpose: decode the fields used by the properties
    always_comb begin
        is_g2w  = (instr[WORD_W-1 -: 3] == 3'b111) & instr[WORD_W-4] & ~instr[0];
        issue   = op_go & is_g2w;
        s_clr   = instr[WORD_W-5];
        s_neg   = instr[WORD_W-6];
        s_zero  = instr[WORD_W-7];
        s_link  = instr[WORD_W-8];
        s_sense = instr[WORD_W-9];
        s_osr   = instr[WORD_W-10];
        s_hlt   = instr[WORD_W-11];
    end

    assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(ac_out) && !skip_req));

    assert_or_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !s_sense && s_neg && ac_in[WORD_W-1]) |=> skip_req);

    assert_or_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !s_sense && s_link && link_in) |=> skip_req);

    assert_and_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && s_sense && s_zero && (ac_in == '0)) |=> !skip_req);

    assert_always_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && s_sense && !s_neg && !s_zero && !s_link) |=> skip_req);

    assert_load_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && s_clr && s_osr) |=> (ac_out == $past(switch_in)));

    assert_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (instr[WORD_W-5:1] == '0)) |=> ((ac_out == $past(ac_in)) && !skip_req));

    assert_skip_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> $past(issue));

    assert_halt_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> $past(issue && s_hlt, 2));
endmodule

bind opr2_skip_unit opr2_skip_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_go      (op_go),
    .instr      (instr),
    .ac_in      (ac_in),
    .link_in    (link_in),
    .switch_in  (switch_in),
    .skip_req   (skip_req),
    .ac_out     (ac_out),
    .halt_pulse (halt_pulse)
);

// File: tb/opr2_skip_unit_test.sv
// Bench for opr2_skip_unit: a behavioural reference model predicts the
// outputs cycle by cycle, and they are compared at every falling edge.
module opr2_skip_unit_test;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_go = 1'b0;
    logic [W-1:0] instr = '0;
    logic [W-1:0] ac_in = '0;
    logic         link_in = 1'b0;
    logic [W-1:0] switch_in = '0;
    logic         skip_req;
    logic [W-1:0] ac_out;
    logic         halt_pulse;

    int n_vec = 0;
    int n_bad = 0;
    int cur_tag = 10;
    bit started = 0;

    // reference model state
    logic [W-1:0] m_ac = '0;
    logic         m_skip = 1'b0;
    logic         m_h1 = 1'b0;
    logic         m_h2 = 1'b0;
    int           m_tag = 10;

    always #4 clk = ~clk;   // 125 MHz

    opr2_skip_unit #(.WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_go(op_go), .instr(instr),
        .ac_in(ac_in), .link_in(link_in), .switch_in(switch_in),
        .skip_req(skip_req), .ac_out(ac_out), .halt_pulse(halt_pulse)
    );

    // Behavioural meaning of one word, written from the requirements
    function automatic void predict(input logic [11:0] w, input logic [11:0] a,
                                    input logic l, input logic [11:0] s,
                                    output bit valid, output bit sk,
                                    output logic [11:0] na, output bit hl);
        int acv;
        acv   = int'(a);
        valid = (w[11:9] == 3'o7) && w[8] && !w[0];
        if (!w[3]) begin
            sk = 0;
            if (w[6] && acv >= 2048) sk = 1;
            if (w[5] && acv == 0)    sk = 1;
            if (w[4] && l)           sk = 1;
        end else begin
            sk = 1;
            if (w[6] && !(acv < 2048)) sk = 0;
            if (w[5] && !(acv != 0))   sk = 0;
            if (w[4] && !(l == 0))     sk = 0;
        end
        if (w[7]) acv = 0;
        if (w[2]) acv = acv | int'(s);
        na = acv[11:0];
        hl = w[1];
    endfunction

    // Model update at each rising edge
    always @(posedge clk) begin
        bit v, sk, hl;
        logic [11:0] na;
        started <= 1;
        if (!rst_n) begin
            m_ac <= '0; m_skip <= 0; m_h1 <= 0; m_h2 <= 0; m_tag <= 10;
        end else begin
            predict(instr, ac_in, link_in, switch_in, v, sk, na, hl);
            if (op_go && v) m_ac <= na;
            m_skip <= op_go && v && sk;
            m_h1   <= op_go && v && hl;
            m_h2   <= m_h1;
            m_tag  <= cur_tag;
        end
    end

    // Compare at every falling edge, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            n_vec++;
            if (ac_out !== m_ac) begin
                n_bad++;
                $display("FAIL R%0d ac_out actual %o expected %o", m_tag, ac_out, m_ac);
            end
            if (skip_req !== m_skip) begin
                n_bad++;
                $display("FAIL R%0d skip_req actual %b expected %b", m_tag, skip_req, m_skip);
            end
            if (halt_pulse !== m_h2) begin
                n_bad++;
                $display("FAIL R9 halt_pulse actual %b expected %b", halt_pulse, m_h2);
            end
        end
    end

    task automatic issue(input int tag, input logic [11:0] w, input logic [11:0] a,
                         input logic l, input logic [11:0] s, input bit go);
        @(negedge clk);
        cur_tag = tag; op_go = go; instr = w; ac_in = a; link_in = l; switch_in = s;
        @(negedge clk);
        op_go = 0; instr = '0;
    endtask

    initial begin
        // R10: reset state, compared during and after reset
        cur_tag = 10;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R7: no-op
        issue(7, 12'o7400, 12'o1234, 1, 12'o7777, 1);
        // R2: OR form
        issue(2, 12'o7500, 12'o4000, 0, 0, 1);
        issue(2, 12'o7500, 12'o3777, 0, 0, 1);
        issue(2, 12'o7440, 12'o0000, 0, 0, 1);
        issue(2, 12'o7420, 12'o0005, 1, 0, 1);
        issue(2, 12'o7460, 12'o0005, 0, 0, 1);
        // R3: AND form
        issue(3, 12'o7510, 12'o0000, 0, 0, 1);
        issue(3, 12'o7510, 12'o4000, 0, 0, 1);
        issue(3, 12'o7450, 12'o0000, 0, 0, 1);
        issue(3, 12'o7470, 12'o0007, 0, 0, 1);
        issue(3, 12'o7570, 12'o0001, 0, 0, 1);
        issue(3, 12'o7570, 12'o0001, 1, 0, 1);
        // R4: unconditional skip
        issue(4, 12'o7410, 12'o4321, 1, 0, 1);
        // R5: skip test sees AC before clear
        issue(5, 12'o7640, 12'o0005, 0, 0, 1);
        issue(5, 12'o7650, 12'o0000, 0, 0, 1);
        // R6: clear and switch OR
        issue(6, 12'o7604, 12'o5555, 0, 12'o1357, 1);
        issue(6, 12'o7404, 12'o7000, 0, 12'o0070, 1);
        issue(6, 12'o7600, 12'o7777, 0, 12'o7777, 1);
        // R9: halt pulse
        issue(9, 12'o7402, 12'o0011, 0, 0, 1);
        issue(9, 12'o7612, 12'o0011, 0, 0, 1);
        // R1: ignored words and idle issue
        issue(1, 12'o7401, 12'o0123, 1, 12'o7777, 1);
        issue(1, 12'o7000, 12'o0123, 1, 12'o7777, 1);
        issue(1, 12'o3640, 12'o0000, 1, 12'o7777, 1);
        issue(1, 12'o7612, 12'o0000, 1, 12'o7777, 0);
        // R8: back-to-back issues, results one cycle later each
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cur_tag = 8;
            op_go   = ($urandom_range(0, 3) != 0);
            instr   = {3'o7, ($urandom_range(0, 7) != 0), 8'($urandom)};
            if ($urandom_range(0, 7) == 0) instr = 12'($urandom);
            ac_in   = ($urandom_range(0, 5) == 0) ? 12'o0 : 12'($urandom);
            link_in = 1'($urandom);
            switch_in = 12'($urandom);
        end
        @(negedge clk);
        op_go = 0;
        // R10: reset in mid-run clears everything
        cur_tag = 10;
        issue(10, 12'o7406, 12'o0000, 0, 12'o1111, 1);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule